// File: doc/BRIEF.md
# Walk Start Address Generator

At the start of a page table walk, this block works out three things: the lookup level at which the walk begins, the base address of the first table, and the address of the first 8-byte descriptor to fetch. Its inputs are the translation base register, the granule size, the region size field, the physical address range and the stage-2 controls. It has a walk-cache path. When a cached table descriptor is supplied, the walk resumes one level below that descriptor. The walk then uses the descriptor's next-table address and its accumulated table permission bits instead of starting from the translation base register.

A single-cycle `start` strobe captures the inputs. One clock later all results appear on registered outputs, qualified by a one-cycle `out_valid` pulse. The outputs then hold until the next strobe. Two flags report problems. `level_err` marks configurations that yield no usable start level. `size_fault` marks a table base that lies beyond a 48-bit physical range. Issuing memory reads, decoding descriptors and raising architectural faults are left to the walker that uses this block.

Top module: `walk_start_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `start` high, and low otherwise. After reset all outputs are 0.
- R2: On a stage-1 miss (`wc_valid`=0, `stage2`=0), let g=`gran_log2`, s=g-3 and ia=64-`t0sz`. The start level is the largest L in 0..3 with ia <= g+s*(4-L). If no such L exists, or if ia <= g, `level_err` is 1. `level_err` is also 1 whenever `gran_log2` is not 12, 14 or 16.
- R3: On a stage-2 miss, the start level is 2-`s2_start` for g=12 and 3-`s2_start` for g=14 or 16. `s2_start`=3 sets `level_err`. On any miss, `level_err` is also set when the base low bit lo=3+ia-s*(3-L)-g falls outside 3..47.
- R4: On a miss with `pa52`=0, `table_base` equals the translation base value with bits below lo and bits 51:48 cleared. The translation base value is `ttb` placed at address bits 47:2.
- R5: On a miss with `pa52`=1, the clear boundary is max(lo,6), and `ttb` bits 5:2 are copied to `table_base` bits 51:48.
- R6: On a hit (`wc_valid`=1), `table_base`=`wc_addr` and `level`=`wc_level`+1. `wc_level`=3 sets `level_err`.
- R7: On a hit, `xn_tbl`=`wc_xn`, `pxn_tbl`=`wc_pxn`, `ro_tbl`=`wc_ap[1]` and `user_tbl`=`wc_ap[0]`. On a miss all four are 0.
- R8: `desc_addr` = (`table_base` + 8 * `vaddr`[ia-1 : s*(3-L)+g]), truncated to 52 bits.
- R9: `size_fault` is 1 exactly when `pa52`=0 and `table_base` bits 51:48 are not all zero.
- R10: In cycles without a strobe, all outputs other than `out_valid` hold their values, even while the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture strobe |
| ttb | input | 46 | Translation base register bits 47:2 |
| gran_log2 | input | 5 | log2 of the granule size (12, 14, 16) |
| t0sz | input | 6 | Region size field; ia = 64 - t0sz |
| pa52 | input | 1 | 1: 52-bit physical range, 0: 48-bit |
| stage2 | input | 1 | Walk is stage 2 |
| s2_start | input | 2 | Stage-2 start-level field |
| vaddr | input | 64 | Input address |
| wc_valid | input | 1 | Walk-cache table entry supplied |
| wc_level | input | 2 | Level of the cached table descriptor |
| wc_addr | input | 52 | Next-table address from the cache entry |
| wc_xn | input | 1 | Cached execute-never table bit |
| wc_pxn | input | 1 | Cached privileged execute-never table bit |
| wc_ap | input | 2 | Cached table access bits: 1 read-only, 0 user |
| out_valid | output | 1 | Results valid pulse |
| level | output | 2 | Start lookup level |
| table_base | output | 52 | First table base address |
| desc_addr | output | 52 | First descriptor address |
| xn_tbl | output | 1 | Inherited execute-never |
| pxn_tbl | output | 1 | Inherited privileged execute-never |
| ro_tbl | output | 1 | Inherited read-only |
| user_tbl | output | 1 | Inherited user access |
| level_err | output | 1 | No valid start level |
| size_fault | output | 1 | Table base beyond the 48-bit range |

## Verification
Every result has the same latency. A strobe at one rising edge makes the outputs valid from that edge until the next one. The bench drives each strobe on a falling edge, compares every field on the following falling edge, and expects `out_valid` high there. On the falling edge after that it expects `out_valid` low and every field unchanged, even though the address inputs were disturbed in between. The sweeps cover every region size for each granule and range on stage 1, every start-level field on stage 2, every cached level on the hit path, and illegal granules.

// File: rtl/walk_start_gen.sv
module walk_start_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:2] ttb,
  input  logic [4:0]  gran_log2,
  input  logic [5:0]  t0sz,
  input  logic        pa52,
  input  logic        stage2,
  input  logic [1:0]  s2_start,
  input  logic [63:0] vaddr,
  input  logic        wc_valid,
  input  logic [1:0]  wc_level,
  input  logic [51:0] wc_addr,
  input  logic        wc_xn,
  input  logic        wc_pxn,
  input  logic [1:0]  wc_ap,
  output logic        out_valid,
  output logic [1:0]  level,
  output logic [51:0] table_base,
  output logic [51:0] desc_addr,
  output logic        xn_tbl,
  output logic        pxn_tbl,
  output logic        ro_tbl,
  output logic        user_tbl,
  output logic        level_err,
  output logic        size_fault
);
  logic [63:0] tb64;
  logic [63:0] base_n, vm, idx;
  logic [51:0] desc_n;
  logic        bad;
  int          g, s, ia, n, lv, lo, z, sh;

  assign tb64 = {16'b0, ttb, 2'b0};

  always_comb begin
    g   = int'(gran_log2);
    bad = !(g == 12 || g == 14 || g == 16);
    if (bad) g = 12;
    s  = g - 3;
    ia = 64 - int'(t0sz);
    n  = 0;
    for (int k = 0; k < 5; k++)
      if (ia > g + s * k) n = n + 1;
    if (wc_valid)
      lv = int'(wc_level) + 1;
    else if (stage2)
      lv = (s2_start == 2'd3) ? 4 : ((g == 12) ? 2 : 3) - int'(s2_start);
    else
      lv = 4 - n;
    if (lv < 0 || lv > 3) begin
      bad = 1'b1;
      lv  = (lv < 0) ? 0 : 3;
    end
    lo = 3 + ia - s * (3 - lv) - g;
    if (!wc_valid && (lo < 3 || lo > 47)) bad = 1'b1;
    z = (lo < 3) ? 3 : ((lo > 47) ? 47 : lo);
    if (pa52 && z < 6) z = 6;
    if (wc_valid)
      base_n = {12'b0, wc_addr};
    else begin
      base_n = (tb64 >> z) << z;
      if (pa52) base_n[51:48] = tb64[5:2];
    end
    sh     = s * (3 - lv) + g;
    vm     = (ia >= 64) ? '1 : ((64'd1 << ia) - 64'd1);
    idx    = (vaddr & vm) >> sh;
    desc_n = 52'(base_n + (idx << 3));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      level      <= '0;
      table_base <= '0;
      desc_addr  <= '0;
      xn_tbl     <= 1'b0;
      pxn_tbl    <= 1'b0;
      ro_tbl     <= 1'b0;
      user_tbl   <= 1'b0;
      level_err  <= 1'b0;
      size_fault <= 1'b0;
    end else begin
      out_valid <= start;
      if (start) begin
        level      <= 2'(lv);
        table_base <= base_n[51:0];
        desc_addr  <= desc_n;
        xn_tbl     <= wc_valid & wc_xn;
        pxn_tbl    <= wc_valid & wc_pxn;
        ro_tbl     <= wc_valid & wc_ap[1];
        user_tbl   <= wc_valid & wc_ap[0];
        level_err  <= bad;
        size_fault <= !pa52 && (|base_n[51:48]);
      end
    end
  end
endmodule

// File: rtl/walk_start_gen_chk.sv
module walk_start_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        pa52,
  input logic        wc_valid,
  input logic [51:0] wc_addr,
  input logic        out_valid,
  input logic [51:0] table_base,
  input logic [51:0] desc_addr,
  input logic [1:0]  level,
  input logic        xn_tbl,
  input logic        pxn_tbl,
  input logic        ro_tbl,
  input logic        user_tbl,
  input logic        level_err,
  input logic        size_fault
);
  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(start));
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(table_base) && $stable(desc_addr) && $stable(level) && $stable(level_err)));
  // R7
  miss_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(wc_valid)) |-> !(xn_tbl || pxn_tbl || ro_tbl || user_tbl));
  // R6
  hit_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(wc_valid)) |-> table_base == $past(wc_addr));
  // R9
  size_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(pa52)) |-> !size_fault);
endmodule

bind walk_start_gen walk_start_gen_chk u_chk (.*);

// File: tb/sim_walk_start_gen.sv
`timescale 1ns/1ps
module sim_walk_start_gen;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [47:2] ttb = '0;
  logic [4:0] gran_log2 = 5'd12;
  logic [5:0] t0sz = '0;
  logic pa52 = 1'b0, stage2 = 1'b0;
  logic [1:0] s2_start = '0;
  logic [63:0] vaddr = '0;
  logic wc_valid = 1'b0;
  logic [1:0] wc_level = '0;
  logic [51:0] wc_addr = '0;
  logic wc_xn = 1'b0, wc_pxn = 1'b0;
  logic [1:0] wc_ap = '0;
  logic out_valid, xn_tbl, pxn_tbl, ro_tbl, user_tbl, level_err, size_fault;
  logic [1:0] level;
  logic [51:0] table_base, desc_addr;
  int tests = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  walk_start_gen u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input int gl, input int tz, input bit p52, input bit s2, input int sl,
                          input bit hit, input int wl, input logic [51:0] wa, input logic [3:0] perm,
                          input logic [63:0] tbv, input logic [63:0] va);
    int g, s, ia, L, lo, z, sh;
    bit err, gok;
    logic [63:0] base, tbw, idx, dsc;
    logic [51:0] h_base, h_desc;
    logic [1:0] h_lvl;
    g = gl; gok = (g == 12 || g == 14 || g == 16);
    if (!gok) g = 12;
    s = g - 3; ia = 64 - tz; err = !gok;
    tbw = {16'b0, tbv[47:2], 2'b0};
    if (hit) begin
      L = wl + 1;
      if (wl == 3) err = 1;
      base = {12'b0, wa};
    end else begin
      if (s2) begin
        if (sl == 3) begin err = 1; L = 0; end
        else L = (g == 12) ? 2 - sl : 3 - sl;
      end else begin
        L = -1;
        for (int c = 0; c < 4; c++) if (ia <= g + s * (4 - c)) L = c;
        if (L < 0 || ia <= g) begin err = 1; L = 0; end
      end
      lo = 3 + ia - s * (3 - L) - g;
      if (lo < 3 || lo > 47) err = 1;
      z = (p52 && lo < 6) ? 6 : lo;
      base = (z >= 3 && z <= 47) ? ((tbw >> z) << z) : 64'd0;
      if (p52) base[51:48] = tbw[5:2];
    end
    if (!err) begin
      sh = s * (3 - L) + g;
      idx = ((va << (64 - ia)) >> (64 - ia)) >> sh;
      dsc = base + idx * 64'd8;
    end
    @(negedge clk);
    ttb = tbv[47:2]; gran_log2 = 5'(gl); t0sz = 6'(tz); pa52 = p52; stage2 = s2;
    s2_start = 2'(sl); vaddr = va; wc_valid = hit; wc_level = 2'(wl); wc_addr = wa;
    wc_xn = perm[3]; wc_pxn = perm[2]; wc_ap = perm[1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid === 1'b1, "R1 valid pulse", 64'(out_valid), 64'd1);
    chk(level_err === err, hit ? "R6 level_err" : (s2 ? "R3 level_err" : "R2 level_err"), 64'(level_err), 64'(err));
    if (!err) begin
      chk(level === 2'(L), hit ? "R6 level" : (s2 ? "R3 level" : "R2 level"), 64'(level), 64'(L));
      chk(table_base === base[51:0], hit ? "R6 base" : (p52 ? "R5 base" : "R4 base"), 64'(table_base), base);
      chk(desc_addr === dsc[51:0], "R8 desc_addr", 64'(desc_addr), 64'(dsc[51:0]));
      chk(size_fault === (!p52 && |base[51:48]), "R9 size_fault", 64'(size_fault), 64'(!p52 && |base[51:48]));
      chk({xn_tbl, pxn_tbl, ro_tbl, user_tbl} === (hit ? perm : 4'b0), "R7 table perms",
          64'({xn_tbl, pxn_tbl, ro_tbl, user_tbl}), 64'(hit ? perm : 4'b0));
    end
    h_base = table_base; h_desc = desc_addr; h_lvl = level;
    vaddr = ~va; wc_addr = ~wa; ttb = ~ttb;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 single pulse", 64'(out_valid), 64'd0);
    chk(table_base === h_base && desc_addr === h_desc && level === h_lvl, "R10 hold",
        64'(desc_addr), 64'(h_desc));
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] tv, vv;
    int i;
    i = 0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && table_base === '0 && desc_addr === '0 && level === '0,
        "R1 reset state", 64'(table_base), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int gi = 0; gi < 3; gi++)
      for (int p = 0; p < 2; p++)
        for (int tz = 0; tz < 64; tz++) begin
          i++;
          tv = 64'hA5C3_9F17_6E2B_D48D ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
          vv = 64'h3C6E_F372_FE94_F82B ^ (64'(i) * 64'hBF58_476D_1CE4_E5B9);
          run_case(12 + 2 * gi, tz, p[0], 1'b0, 0, 1'b0, 0, '0, 4'b0, tv, vv);
        end
    for (int gi = 0; gi < 3; gi++)
      for (int p = 0; p < 2; p++)
        for (int sl = 0; sl < 4; sl++)
          for (int t = 0; t < 5; t++) begin
            i++;
            tv = 64'h1234_5678_9ABC_DEF1 ^ (64'(i) * 64'h94D0_49BB_1331_11EB);
            vv = 64'hFEDC_BA98_7654_3210 ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
            run_case(12 + 2 * gi, 16 + 6 * t, p[0], 1'b1, sl, 1'b0, 0, '0, 4'b0, tv, vv);
          end
    for (int gi = 0; gi < 3; gi++)
      for (int p = 0; p < 2; p++)
        for (int wl = 0; wl < 4; wl++)
          for (int hi = 0; hi < 2; hi++) begin
            i++;
            tv = 64'h0F0F_1234_5555_AAAA ^ 64'(i);
            vv = 64'h0000_7ABC_DEF0_1234 ^ (64'(i) * 64'hBF58_476D_1CE4_E5B9);
            run_case(12 + 2 * gi, 16 + 2 * wl, p[0], 1'b0, 0, 1'b1, wl,
                     {(hi != 0) ? 4'h3 : 4'h0, 36'h8_1234_5000 + 36'(i << 12), 12'h000},
                     4'(i), tv, vv);
          end
    run_case(13, 16, 1'b0, 1'b0, 0, 1'b0, 0, '0, 4'b0, 64'h1111_2222_3333_4444, 64'h5);
    run_case(15, 25, 1'b1, 1'b1, 1, 1'b0, 0, '0, 4'b0, 64'h1111_2222_3333_4444, 64'h5);
    run_case(0, 25, 1'b0, 1'b0, 0, 1'b1, 1, 52'h1000, 4'hF, 64'h1111_2222_3333_4444, 64'h5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule